// File: doc/BRIEF.md
# Striped Multi-Lane ADC Word Aligner

This block sits behind the fixed 8:1 input deserializers of a high-speed serial ADC. That ADC streams its samples over several data lanes and one frame lane. Each data lane carries whole 8-bit samples, one bit after another. Consecutive samples are dealt round-robin across the lanes. The frame lane repeats a fixed square pattern whose rising edge marks where every sample word starts.

On each fabric clock the block receives one 8-bit chunk per lane, taken at an arbitrary boundary. It keeps the previous chunk of each lane and cuts an 8-bit word out of the 16-bit window, at an offset chosen by a bitslip counter. While the frame word taken at that offset differs from the expected pattern, it advances the offset by one bit and lets the word settle before looking again. After enough consecutive matches it declares lock. From then on it presents one aligned sample per lane on every clock. Before a sample is packed, its lane's polarity can be flipped and its bit order can be set to least- or most-significant bit first.

Any frame mismatch after lock drops the lock and starts the hunt again. Downstream logic uses the valid strobe to take only words from frames that checked correctly under lock.

Top module: `lane_word_aligner`

## Requirements
- R1: Bit 0 of every input chunk is the earliest-arrived bit, and the chunks of one lane form a continuous bit stream. The aligned word of a lane is the 8 consecutive stream bits that start at offset `s` (0 to 7) within the previous chunk. Offset `s` may cross into the current chunk. One offset is shared by all lanes.
- R2: The frame word matches when its arrival order is 1,1,1,1,0,0,0,0. Each mismatch while hunting advances the offset by exactly one bit, wrapping from 7 back to 0.
- R3: After reset, and after every offset step, the block skips 2 clocks before it compares again. A stream with frame skew `D` therefore first matches at edge 2+3·D after reset.
- R4: `locked` rises after 16 consecutive matching frame words. With skew `D` it is first high after edge 17+3·D.
- R5: A mismatch while locked clears `locked` after that edge. It also steps the offset and starts the hunt again, so a single corrupt frame checked at edge `E` leads to relock after edge `E`+39.
- R6: When bit `l` of `invMask` is 1, every bit of lane `l` is complemented before its sample is formed.
- R7: With `msbFirst`=0 the earliest-arrived bit is sample bit 0. With `msbFirst`=1 the earliest-arrived bit is sample bit 7.
- R8: Lane `l` drives `sampleOut[8l+7:8l]`, so the oldest sample of each frame sits in the lowest byte.
- R9: `sampleOut` and `sampleValid` are registered. After edge `t` they carry the frame whose last bit arrived by the chunk of edge `t`. `sampleValid` is 1 only when `locked` held and that frame matched, so it is never high while `locked` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock, one-eighth of the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| laneChunk | input | LANES*8 | Raw 8-bit chunk per data lane, lane `l` at bits [8l+7:8l], bit 0 earliest |
| frameChunk | input | 8 | Raw 8-bit chunk of the frame lane, bit 0 earliest |
| invMask | input | LANES | Per-lane polarity flip |
| msbFirst | input | 1 | Bit order select: 0 = LSB arrives first |
| sampleOut | output | LANES*8 | Aligned samples, oldest in the lowest byte |
| sampleValid | output | 1 | Samples on `sampleOut` belong to a checked frame under lock |
| locked | output | 1 | Frame alignment has been found and is holding |

## Verification
The block is driven with frame skews of 0, 3, 5 and 7 bits. Zero skew shows that no slip happens when none is needed. The other skews give distinct lock edges, which separates an off-by-one in the offset stepping or in the settle wait from a correct hunt. Each run also uses a different invert mask and bit order, so a wrong complement, a reversed bit order or a swapped lane lands in a mismatching byte. Two runs flip one bit of a single frame-lane word after lock. This proves the drop, the wrap-around of the offset through all eight positions, and the exact relock edge.

// File: rtl/aligner_pkg.sv
package aligner_pkg;

  // Strobes handed from the lock controller to the datapath.
  typedef struct packed {
    logic slipStep;  // advance the word boundary by one bit
    logic emitOk;    // current frame matched while locked
  } aligner_ctrl_t;

  typedef enum logic [1:0] {
    ST_SETTLE = 2'd0,
    ST_HUNT   = 2'd1,
    ST_LOCKED = 2'd2
  } align_state_t;

endpackage

// File: rtl/aligner_datapath.sv
module aligner_datapath
  import aligner_pkg::*;
#(
  parameter int LANES = 4,
  parameter int WORD = 8,
  parameter logic [WORD-1:0] FRAME_PATTERN = 8'hF0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [LANES*WORD-1:0] laneChunk,
  input  logic [WORD-1:0]       frameChunk,
  input  logic [LANES-1:0]      invMask,
  input  logic                  msbFirst,
  input  aligner_ctrl_t         ctrlIn,
  output logic                  frameMatch,
  output logic [LANES*WORD-1:0] sampleOut,
  output logic                  sampleValid
);

  localparam int SLIPW = $clog2(WORD);

  logic [SLIPW-1:0]      slipPos;
  logic [LANES*WORD-1:0] prevLane;
  logic [WORD-1:0]       prevFrame;
  logic [WORD-1:0]       frameWord;
  logic [LANES*WORD-1:0] assembled;

  // Word with the earliest-arrived bit in the MSB position.
  function automatic logic [WORD-1:0] pickWord(input logic [WORD-1:0] cur,
                                               input logic [WORD-1:0] prv,
                                               input logic [SLIPW-1:0] s);
    logic [2*WORD-1:0] win;
    logic [WORD-1:0] w;
    win = {cur, prv} >> s;
    for (int k = 0; k < WORD; k++) w[WORD-1-k] = win[k];
    return w;
  endfunction

  function automatic logic [WORD-1:0] flipOrder(input logic [WORD-1:0] v);
    logic [WORD-1:0] r;
    for (int k = 0; k < WORD; k++) r[k] = v[WORD-1-k];
    return r;
  endfunction

  assign frameWord  = pickWord(frameChunk, prevFrame, slipPos);
  assign frameMatch = (frameWord == FRAME_PATTERN);

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [WORD-1:0] arrival;
    logic [WORD-1:0] ordered;
    assign arrival = pickWord(laneChunk[g*WORD +: WORD], prevLane[g*WORD +: WORD], slipPos);
    assign ordered = msbFirst ? arrival : flipOrder(arrival);
    assign assembled[g*WORD +: WORD] = ordered ^ {WORD{invMask[g]}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slipPos     <= '0;
      prevLane    <= '0;
      prevFrame   <= '0;
      sampleOut   <= '0;
      sampleValid <= 1'b0;
    end else begin
      prevLane    <= laneChunk;
      prevFrame   <= frameChunk;
      sampleOut   <= assembled;
      sampleValid <= ctrlIn.emitOk;
      if (ctrlIn.slipStep)
        slipPos <= (slipPos == SLIPW'(WORD-1)) ? '0 : slipPos + 1'b1;
    end
  end

  // R2: the boundary only ever moves by a single bit, with wrap.
  assert_slip_single_R2: assert property (@(posedge clk) disable iff (rst)
    (slipPos != $past(slipPos)) |->
      (slipPos == (($past(slipPos) == SLIPW'(WORD-1)) ? '0 : $past(slipPos) + 1'b1)));

  // R3: two quiet clocks follow every boundary step.
  assert_settle_gap_R3: assert property (@(posedge clk) disable iff (rst)
    $past(ctrlIn.slipStep) |-> !ctrlIn.slipStep);
  assert_settle_gap2_R3: assert property (@(posedge clk) disable iff (rst)
    $past(ctrlIn.slipStep, 2) |-> !ctrlIn.slipStep);

endmodule

// File: rtl/aligner_lock_ctrl.sv
module aligner_lock_ctrl
  import aligner_pkg::*;
#(
  parameter int LOCK_COUNT = 16,
  parameter int SETTLE_CYC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frameMatch,
  output aligner_ctrl_t ctrlOut,
  output logic          locked
);

  localparam int CNTW  = $clog2(LOCK_COUNT);
  localparam int WAITW = $clog2(SETTLE_CYC + 1);

  align_state_t     state;
  logic [CNTW-1:0]  matchCnt;
  logic [WAITW-1:0] waitCnt;

  assign locked = (state == ST_LOCKED);

  always_comb begin
    ctrlOut = '0;
    case (state)
      ST_HUNT:   ctrlOut.slipStep = !frameMatch;
      ST_LOCKED: begin
        ctrlOut.emitOk   = frameMatch;
        ctrlOut.slipStep = !frameMatch;
      end
      default:   ctrlOut = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_SETTLE;
      waitCnt  <= WAITW'(SETTLE_CYC);
      matchCnt <= '0;
    end else begin
      case (state)
        ST_SETTLE: begin
          if (waitCnt <= WAITW'(1)) state <= ST_HUNT;
          waitCnt <= waitCnt - 1'b1;
        end
        ST_HUNT: begin
          if (frameMatch) begin
            if (matchCnt == CNTW'(LOCK_COUNT-1)) begin
              state    <= ST_LOCKED;
              matchCnt <= '0;
            end else begin
              matchCnt <= matchCnt + 1'b1;
            end
          end else begin
            matchCnt <= '0;
            state    <= ST_SETTLE;
            waitCnt  <= WAITW'(SETTLE_CYC);
          end
        end
        ST_LOCKED: begin
          if (!frameMatch) begin
            state   <= ST_SETTLE;
            waitCnt <= WAITW'(SETTLE_CYC);
          end
        end
        default: state <= ST_SETTLE;
      endcase
    end
  end

  // R4: lock is only entered from the hunt, on a matching frame.
  assert_lock_entry_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> ($past(frameMatch) && $past(state) == ST_HUNT));

  // R5: a bad frame while locked drops the lock at once.
  assert_unlock_on_miss_R5: assert property (@(posedge clk) disable iff (rst)
    (locked && !frameMatch) |=> !locked);

endmodule

// File: rtl/lane_word_aligner.sv
module lane_word_aligner
  import aligner_pkg::*;
#(
  parameter int LANES = 4,
  parameter int WORD = 8,
  parameter logic [WORD-1:0] FRAME_PATTERN = 8'hF0,
  parameter int LOCK_COUNT = 16,
  parameter int SETTLE_CYC = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [LANES*WORD-1:0] laneChunk,
  input  logic [WORD-1:0]       frameChunk,
  input  logic [LANES-1:0]      invMask,
  input  logic                  msbFirst,
  output logic [LANES*WORD-1:0] sampleOut,
  output logic                  sampleValid,
  output logic                  locked
);

  aligner_ctrl_t ctrl;
  logic          frameMatch;

  aligner_datapath #(
    .LANES(LANES), .WORD(WORD), .FRAME_PATTERN(FRAME_PATTERN)
  ) u_dp (
    .clk(clk), .rst(rst), .laneChunk(laneChunk), .frameChunk(frameChunk),
    .invMask(invMask), .msbFirst(msbFirst), .ctrlIn(ctrl),
    .frameMatch(frameMatch), .sampleOut(sampleOut), .sampleValid(sampleValid)
  );

  aligner_lock_ctrl #(
    .LOCK_COUNT(LOCK_COUNT), .SETTLE_CYC(SETTLE_CYC)
  ) u_ctl (
    .clk(clk), .rst(rst), .frameMatch(frameMatch), .ctrlOut(ctrl), .locked(locked)
  );

  // R9: no valid word leaves the block unless alignment holds.
  assert_valid_needs_lock_R9: assert property (@(posedge clk) disable iff (rst)
    sampleValid |-> locked);

endmodule

// File: tb/sim_lane_word_aligner.sv
module sim_lane_word_aligner;
  localparam int LANES = 4;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [LANES*W-1:0] laneChunk = '0;
  logic [W-1:0] frameChunk = '0;
  logic [LANES-1:0] invMask = '0;
  logic msbFirst = 1'b0;
  logic [LANES*W-1:0] sampleOut;
  logic sampleValid;
  logic locked;

  lane_word_aligner u0 (
    .clk(clk), .rst(rst), .laneChunk(laneChunk), .frameChunk(frameChunk),
    .invMask(invMask), .msbFirst(msbFirst), .sampleOut(sampleOut),
    .sampleValid(sampleValid), .locked(locked)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  int runD, runCorr, lockEdge, relockEdge, edgeIdx, validSeen;
  bit running = 0;
  logic [LANES*W-1:0] expQ[$];

  function automatic logic [7:0] sampleVal(input int n);
    return 8'(((n + 4096) * 73 + 19) & 255);
  endfunction

  function automatic logic [LANES*W-1:0] frameVec(input int f);
    logic [LANES*W-1:0] v;
    for (int l = 0; l < LANES; l++) v[l*W +: W] = sampleVal(f * LANES + l);
    return v;
  endfunction

  // Bit at stream position p of a lane; lane = -1 selects the frame lane.
  function automatic logic streamBit(input int lane, input int p);
    int q, f, b;
    logic [7:0] v;
    q = p - runD + 8;
    f = q / 8 - 1;
    b = q % 8;
    if (lane < 0) return ((b < 4) ? 1'b1 : 1'b0) ^ ((f == runCorr && b == 6) ? 1'b1 : 1'b0);
    v = sampleVal(f * LANES + lane);
    return (msbFirst ? v[7-b] : v[b]) ^ invMask[lane];
  endfunction

  task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // Monitor: one expected item per edge, compared just after the edge.
  initial forever begin
    @(posedge clk);
    #2;
    if (running && expQ.size() > 0) begin
      logic [LANES*W-1:0] exp;
      bit lockExp, validExp;
      int e;
      exp = expQ.pop_front();
      e = edgeIdx;
      edgeIdx++;
      lockExp  = (e >= lockEdge && (runCorr < 0 || e <= runCorr + 1 - 1)) ||
                 (runCorr >= 0 && e >= relockEdge);
      validExp = (e >= lockEdge + 1 && (runCorr < 0 || e <= runCorr)) ||
                 (runCorr >= 0 && e >= relockEdge + 1);
      // R2 R3 R4 R5: exact lock timeline for this skew
      check(locked == lockExp, $sformatf("R4 R5 locked at edge %0d", e), 64'(locked), 64'(lockExp));
      // R9: valid strobe timeline
      check(sampleValid == validExp, $sformatf("R9 sampleValid at edge %0d", e), 64'(sampleValid), 64'(validExp));
      if (sampleValid) begin
        validSeen++;
        // R1 R6 R7 R8: aligned, polarity-fixed, ordered, packed samples
        check(sampleOut == exp, $sformatf("R1 R6 R7 R8 samples at edge %0d", e), 64'(sampleOut), 64'(exp));
      end
    end
  end

  // Driver: feeds chunks and pushes the frame each edge should present.
  task automatic doRun(input int d, input bit msb, input logic [LANES-1:0] inv,
                       input int corr, input int total);
    int expValid;
    runD = d; runCorr = corr;
    msbFirst = msb; invMask = inv;
    lockEdge = 17 + 3 * d;
    relockEdge = corr + 40;
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(locked == 1'b0, "R4 reset locked", 64'(locked), 64'd0);
    check(sampleValid == 1'b0, "R9 reset valid", 64'(sampleValid), 64'd0);
    check(sampleOut == '0, "R9 reset samples", 64'(sampleOut), 64'd0);
    expQ.delete();
    edgeIdx = 0;
    validSeen = 0;
    for (int t = 0; t < total; t++) begin
      @(negedge clk);
      rst = 1'b0;
      for (int l = 0; l < LANES; l++)
        for (int b = 0; b < W; b++) laneChunk[l*W + b] = streamBit(l, 8 * t + b);
      for (int b = 0; b < W; b++) frameChunk[b] = streamBit(-1, 8 * t + b);
      expQ.push_back(frameVec(t - 1));
      running = 1;
    end
    @(negedge clk);
    running = 0;
    if (corr < 0) expValid = total - 1 - lockEdge;
    else expValid = (corr - lockEdge) + (total - 1 - relockEdge);
    check(validSeen == expValid, "R9 count of valid words", 64'(validSeen), 64'(expValid));
  endtask

  initial begin
    doRun(0, 1'b0, 4'b0000, -100, 60);
    doRun(3, 1'b1, 4'b0101, -100, 70);
    doRun(7, 1'b0, 4'b1000, 50, 120);
    doRun(5, 1'b1, 4'b1111, 40, 110);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule